// File: doc/BRIEF.md
# Per-Pixel Colour Source Selector

This block turns a stream of fetched frame-buffer pixels into a stream of 24-bit RGB output pixels, one per cycle. Every pixel in a scanned line arrives as three fields: an 8-bit palette index, a 32-bit direct-colour word and a 32-bit control word. The top byte of the control word is a tag. The tag decides, pixel by pixel, whether the output colour comes from an external palette lookup of the index or straight from the direct-colour word.

Every plane is stored with a fixed line stride of `STRIDE` pixels (1024 by default). The active width and height are set on configuration inputs, up to `STRIDE` by `MAX_H` (1024 by 768 by default). The upstream fetch supplies every pixel of every stride. The block tracks the scan position itself, drops pixels beyond the active width, and marks the start of each line and the last pixel of the frame. The palette is an external synchronous read port with a read enable. The direct path is registered once, so both sources reach the output mux in the same cycle and pixel order is kept.

Top module: `cplane_pixel_mux`

## Requirements
- R1: A pixel whose control word has bits [31:24] equal to 8'h03 is output in direct colour. Any other tag value, including 8'h00, 8'h02, 8'h13, 8'h83 and 8'hFF, gives the palette colour for that pixel's index. Control bits [23:0] have no effect.
- R2: The direct-colour word holds blue in [23:16], green in [15:8] and red in [7:0], and its bits [31:24] are ignored. `outRgb` carries red in [23:16], green in [15:8] and blue in [7:0].
- R3: Input beats are consumed in scan order, `STRIDE` per line, `cfgHeight` lines per frame. Only beats whose column is below `cfgWidth` produce an output pixel. The others are accepted and never emitted.
- R4: `outSol` is 1 exactly on the output pixel from column 0 of a line.
- R5: `outEof` is 1 exactly on the output pixel at column `cfgWidth`-1 of line `cfgHeight`-1. The next input beat after that frame's last stride starts a new frame at line 0.
- R6: While `outValid` is 1 and `outReady` is 0, the output pixel and its flags hold unchanged. Output pixels leave in input order.
- R7: After reset, `outValid` is 0, `inReady` is 1 and the scan position is line 0, column 0.
- R8: `palRe` pulses once for each accepted beat that will be emitted, with `palIdx` equal to that beat's index byte. It never pulses for a skipped beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgWidth | input | $clog2(STRIDE+1) | Active pixels per line, 1..STRIDE |
| cfgHeight | input | $clog2(MAX_H+1) | Active lines per frame, 1..MAX_H |
| inValid | input | 1 | Input pixel beat present |
| inReady | output | 1 | Block accepts the beat this cycle |
| inIdx | input | 8 | Index-plane byte of the pixel |
| inDirect | input | 32 | Direct-colour word, blue-green-red in the low 24 bits |
| inCtrl | input | 32 | Control-plane word, tag in [31:24] |
| palRe | output | 1 | Palette read enable |
| palIdx | output | 8 | Palette read address |
| palColor | input | 24 | Palette data, {r,g,b}, valid the cycle after `palRe` and held until the next one |
| outValid | output | 1 | Output pixel present |
| outReady | input | 1 | Sink takes the output pixel |
| outRgb | output | 24 | Output colour {r,g,b} |
| outSol | output | 1 | First pixel of a line |
| outEof | output | 1 | Last pixel of the frame |

## Verification
The assertions assume that `cfgWidth` and `cfgHeight` are non-zero, within range, and changed only while the scan sits at the start of a frame with no pixel in flight. They also assume that the palette holds its data between read enables. The bench meets these conditions by changing the configuration only after its scoreboard queue has drained at a frame boundary, and its palette model updates only on `palRe`. Within those limits, the stimulus adds random input gaps and random output stalls, and it mixes direct and palette tags with junk in the ignored bytes.

// File: rtl/cpsel_pkg.sv
package cpsel_pkg;
  localparam logic [7:0] DIRECT_TAG = 8'h03;

  typedef struct packed {
    logic take;  // beat handshake completes this cycle
    logic keep;  // beat column lies inside the active width
    logic sol;   // beat sits in column 0
    logic eof;   // beat is the last active pixel of the frame
  } beatStrobe_t;
endpackage

// File: rtl/cpsel_ctrl.sv
module cpsel_ctrl
  import cpsel_pkg::*;
#(
  parameter int STRIDE = 1024,
  parameter int MAX_H  = 768
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        inValid,
  input  logic                        stageFree,
  input  logic [$clog2(STRIDE+1)-1:0] cfgWidth,
  input  logic [$clog2(MAX_H+1)-1:0]  cfgHeight,
  output logic                        inReady,
  output logic                        palRe,
  output beatStrobe_t                 strb
);
  localparam int XW = $clog2(STRIDE);
  localparam int YW = $clog2(MAX_H);
  localparam int WW = $clog2(STRIDE+1);
  localparam int HW = $clog2(MAX_H+1);

  logic [XW-1:0] xPos;
  logic [YW-1:0] yPos;
  logic          lastX;
  logic          lastY;

  assign lastX = (xPos == XW'(STRIDE - 1));
  assign lastY = (HW'(yPos) == cfgHeight - HW'(1));

  assign inReady   = stageFree;
  assign strb.take = inValid && stageFree;
  assign strb.keep = WW'(xPos) < cfgWidth;
  assign strb.sol  = (xPos == '0);
  assign strb.eof  = lastY && (WW'(xPos) == cfgWidth - WW'(1));
  assign palRe     = strb.take && strb.keep;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      xPos <= '0;
      yPos <= '0;
    end else if (strb.take) begin
      if (lastX) begin
        xPos <= '0;
        yPos <= lastY ? '0 : yPos + YW'(1);
      end else begin
        xPos <= xPos + XW'(1);
      end
    end
  end

  AST_Y_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    HW'(yPos) < cfgHeight); // R5

  AST_PAL_GATED: assert property (@(posedge clk) disable iff (!rstN)
    palRe |-> (inValid && inReady)); // R8
endmodule

// File: rtl/cpsel_dp.sv
module cpsel_dp
  import cpsel_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  beatStrobe_t strb,
  input  logic [7:0]  inIdx,
  input  logic [31:0] inDirect,
  input  logic [31:0] inCtrl,
  input  logic [23:0] palColor,
  input  logic        outReady,
  output logic        stageFree,
  output logic [7:0]  palIdx,
  output logic        outValid,
  output logic [23:0] outRgb,
  output logic        outSol,
  output logic        outEof
);
  localparam int BYTES = 3;

  logic [23:0] directRgb;
  logic        isDirect;
  logic        unusedBits;

  logic        s1Valid;
  logic        s1Direct;
  logic [23:0] s1Rgb;
  logic        s1Sol;
  logic        s1Eof;

  // storage is b,g,r from high to low; output is r,g,b from high to low
  for (genvar g = 0; g < BYTES; g++) begin : gSwap
    assign directRgb[8*g +: 8] = inDirect[8*(BYTES-1-g) +: 8];
  end

  assign isDirect   = (inCtrl[31:24] == DIRECT_TAG);
  assign unusedBits = ^{inCtrl[23:0], inDirect[31:24]};
  assign palIdx     = inIdx;
  assign stageFree  = !s1Valid || outReady;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s1Valid  <= 1'b0;
      s1Direct <= 1'b0;
      s1Rgb    <= '0;
      s1Sol    <= 1'b0;
      s1Eof    <= 1'b0;
    end else if (stageFree) begin
      s1Valid <= strb.take && strb.keep;
      if (strb.take && strb.keep) begin
        s1Direct <= isDirect;
        s1Rgb    <= directRgb;
        s1Sol    <= strb.sol;
        s1Eof    <= strb.eof;
      end
    end
  end

  assign outValid = s1Valid;
  assign outRgb   = s1Direct ? s1Rgb : palColor;
  assign outSol   = s1Sol;
  assign outEof   = s1Eof;

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (s1Valid && !outReady) |=> (s1Valid && $stable(s1Rgb) && $stable(s1Direct)
                                && $stable(s1Sol) && $stable(s1Eof))); // R6

  AST_OUT_FROM_KEPT: assert property (@(posedge clk) disable iff (!rstN)
    $rose(s1Valid) |-> $past(strb.take && strb.keep)); // R3
endmodule

// File: rtl/cplane_pixel_mux.sv
module cplane_pixel_mux
  import cpsel_pkg::*;
#(
  parameter int STRIDE = 1024,
  parameter int MAX_H  = 768
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [$clog2(STRIDE+1)-1:0] cfgWidth,
  input  logic [$clog2(MAX_H+1)-1:0]  cfgHeight,
  input  logic                        inValid,
  output logic                        inReady,
  input  logic [7:0]                  inIdx,
  input  logic [31:0]                 inDirect,
  input  logic [31:0]                 inCtrl,
  output logic                        palRe,
  output logic [7:0]                  palIdx,
  input  logic [23:0]                 palColor,
  output logic                        outValid,
  input  logic                        outReady,
  output logic [23:0]                 outRgb,
  output logic                        outSol,
  output logic                        outEof
);
  beatStrobe_t strb;
  logic        stageFree;

  cpsel_ctrl #(.STRIDE(STRIDE), .MAX_H(MAX_H)) uCtrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .stageFree(stageFree),
    .cfgWidth(cfgWidth), .cfgHeight(cfgHeight),
    .inReady(inReady), .palRe(palRe), .strb(strb)
  );

  cpsel_dp uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .inIdx(inIdx), .inDirect(inDirect),
    .inCtrl(inCtrl), .palColor(palColor), .outReady(outReady),
    .stageFree(stageFree), .palIdx(palIdx), .outValid(outValid),
    .outRgb(outRgb), .outSol(outSol), .outEof(outEof)
  );
endmodule

// File: tb/sim_cplane_pixel_mux.sv
module sim_cplane_pixel_mux;
  localparam int STRIDE = 8;
  localparam int MAX_H  = 4;
  localparam int WW = $clog2(STRIDE+1);
  localparam int HW = $clog2(MAX_H+1);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [WW-1:0] cfgWidth = WW'(5);
  logic [HW-1:0] cfgHeight = HW'(3);
  logic inValid = 1'b0;
  logic inReady;
  logic [7:0] inIdx = '0;
  logic [31:0] inDirect = '0;
  logic [31:0] inCtrl = '0;
  logic palRe;
  logic [7:0] palIdx;
  logic [23:0] palColor = '0;
  logic outValid;
  logic outReady = 1'b0;
  logic [23:0] outRgb;
  logic outSol;
  logic outEof;

  int checks = 0;
  int errors = 0;
  int expKept = 0;
  int gotOut = 0;
  int palCount = 0;
  bit fullReady = 0;
  bit done = 0;
  logic [25:0] expQ[$];

  always #5 clk = ~clk;

  cplane_pixel_mux #(.STRIDE(STRIDE), .MAX_H(MAX_H)) u0 (
    .clk(clk), .rstN(rstN), .cfgWidth(cfgWidth), .cfgHeight(cfgHeight),
    .inValid(inValid), .inReady(inReady), .inIdx(inIdx), .inDirect(inDirect),
    .inCtrl(inCtrl), .palRe(palRe), .palIdx(palIdx), .palColor(palColor),
    .outValid(outValid), .outReady(outReady), .outRgb(outRgb),
    .outSol(outSol), .outEof(outEof)
  );

  function automatic logic [23:0] palFn(input logic [7:0] i);
    return {i, ~i, i ^ 8'h5A};
  endfunction

  // palette model: synchronous read with enable, data held otherwise
  always @(posedge clk) begin
    if (palRe) begin
      palColor <= palFn(palIdx);
      palCount <= palCount + 1;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic sendFrame(input int w, input int h, input bit gaps);
    logic [7:0] tags[6] = '{8'h03, 8'h00, 8'h02, 8'h83, 8'hFF, 8'h13};
    cfgWidth  = WW'(w);
    cfgHeight = HW'(h);
    for (int y = 0; y < h; y++) begin
      for (int x = 0; x < STRIDE; x++) begin
        logic [7:0] idx;
        logic [31:0] dir;
        logic [31:0] ctl;
        logic [23:0] rgb;
        bit acc;
        idx = 8'($urandom);
        dir = $urandom;
        ctl = {tags[$urandom % 6], 24'($urandom)};
        rgb = (ctl[31:24] == 8'h03) ? {dir[7:0], dir[15:8], dir[23:16]} : palFn(idx);
        if (x < w) begin
          expQ.push_back({rgb, x == 0, (x == w-1) && (y == h-1)});
          expKept++;
        end
        if (gaps && ($urandom % 4 == 0)) @(negedge clk);
        inIdx = idx; inDirect = dir; inCtrl = ctl; inValid = 1'b1;
        do begin
          #4 acc = inReady;
          @(negedge clk);
        end while (!acc);
        inValid = 1'b0;
      end
    end
  endtask

  task automatic drain();
    for (int i = 0; i < 2000 && expQ.size() != 0; i++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  // monitor / scoreboard
  initial begin
    bit stalled = 0;
    logic [23:0] heldRgb = '0;
    logic [25:0] e;
    forever begin
      @(negedge clk);
      outReady = fullReady ? 1'b1 : (($urandom % 3) != 0);
      #4;
      if (rstN) begin
        if (stalled) // R6: held pixel while stalled
          check(outValid && outRgb == heldRgb, "R6", {8'h0, outRgb}, {8'h0, heldRgb});
        stalled = outValid && !outReady;
        heldRgb = outRgb;
        if (outValid && outReady) begin
          gotOut++;
          if (expQ.size() == 0) begin
            check(0, "R3 unexpected output", {8'h0, outRgb}, 32'h0);
          end else begin
            e = expQ.pop_front();
            check(outRgb == e[25:2], "R1/R2 colour", {8'h0, outRgb}, {8'h0, e[25:2]});
            check(outSol == e[1], "R4 sol", {31'h0, outSol}, {31'h0, e[1]});
            check(outEof == e[0], "R5 eof", {31'h0, outEof}, {31'h0, e[0]});
          end
        end
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(outValid == 1'b0, "R7 outValid", {31'h0, outValid}, 32'h0);
    check(inReady == 1'b1, "R7 inReady", {31'h0, inReady}, 32'h1);
    rstN = 1'b1;
    @(negedge clk);
    sendFrame(5, 3, 1);        // R3 skip, R1 mixed tags, stalls
    sendFrame(5, 3, 0);        // R5 wrap into second frame
    drain();
    fullReady = 1;
    sendFrame(STRIDE, 2, 0);   // full-width lines, no skip
    drain();
    fullReady = 0;
    sendFrame(1, 1, 1);        // single-pixel frame: sol and eof together
    drain();
    check(expQ.size() == 0, "R3 leftover", expQ.size(), 32'h0);
    check(gotOut == expKept, "R3 output count", gotOut, expKept);
    check(palCount == expKept, "R8 palette reads", palCount, expKept);
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule